// File: doc/BRIEF.md
# Ownership-Handoff Shared Mailbox

This block is an eight-word, 32-bit mailbox that a requester and a responder share inside a device. Each side has its own plain register port: a write strobe, a word address, write data and combinational read data. Exactly one side owns the mailbox at a time. The ownership flag is bit 31 of the last word, and a set flag means the responder holds it. The requester fills the payload words and then writes the last word, which hands the mailbox over. The responder answers by writing a header into the last word with bit 31 clear, which hands the mailbox back.

The requester side also has a function-reset level. While it is high, both read ports return all ones for every address and requester writes have no effect. The stored contents stay in place and show again once the level drops. A sticky error flag records any requester write made while the responder owned the mailbox. A one-cycle doorbell tells the responder that a handoff has just happened.

Top module: `handoff_mbox`

## Requirements
- R1: The mailbox holds eight 32-bit words at addresses 0 to 7. A word that the requester writes while it owns the mailbox reads back unchanged on the next cycle.
- R2: After the synchronous power-on reset, every word reads as zero, rsp_owns is 0 (the requester owns the mailbox), req_err is 0 and doorbell is 0.
- R3: An accepted requester write to word 7 stores the written data with bit 31 forced to 1, and rsp_owns reads 1 from the next cycle.
- R4: doorbell is high for exactly one cycle: the cycle after an accepted requester write to word 7.
- R5: A responder write to word 7 with bit 31 clear returns ownership, so rsp_owns reads 0 on the next cycle. With bit 31 set, the responder keeps ownership. The written value is stored as given.
- R6: A requester write made while rsp_owns is 1 is ignored, and the addressed word keeps its value.
- R7: Such a blocked write sets req_err on the next cycle. req_err then stays set until power-on reset.
- R8: While fn_rst is 1, req_rdata and rsp_rdata read 0xFFFFFFFF for every address. Requester writes are ignored and do not set req_err. Stored contents show again after fn_rst falls.
- R9: When both sides write the same word in the same cycle, the data of the current owner is stored.
- R10: The responder may write any word at any time. A responder write and a requester write to different words in the same cycle are both stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| fn_rst | input | 1 | Requester function reset in progress |
| req_we | input | 1 | Requester write strobe |
| req_addr | input | 3 | Requester word address |
| req_wdata | input | 32 | Requester write data |
| req_rdata | output | 32 | Requester read data |
| rsp_we | input | 1 | Responder write strobe |
| rsp_addr | input | 3 | Responder word address |
| rsp_wdata | input | 32 | Responder write data |
| rsp_rdata | output | 32 | Responder read data |
| rsp_owns | output | 1 | Ownership flag, 1 when the responder owns the mailbox |
| doorbell | output | 1 | One-cycle pulse after a handoff to the responder |
| req_err | output | 1 | Sticky flag for requester writes made without ownership |

## Verification
Assertions check the following on every cycle:
- the state right after reset;
- that a requester write to the last word raises ownership together with the doorbell;
- that the doorbell never lasts two cycles;
- that a responder header with bit 31 clear releases ownership;
- that blocked or function-reset writes leave the addressed word unchanged;
- that the error flag is set by blocked writes and then never clears;
- that the requester's data wins a collision while it owns the mailbox.

Only the bench scenarios show the actual stored values. These include the forced bit 31 in the handoff word, the responder winning a collision while it owns the mailbox, the all-ones read-back on both ports during function reset, and the contents reappearing after function reset ends.

// File: rtl/handoff_mbox_pkg.sv
package handoff_mbox_pkg;

    localparam int unsigned MBOX_WORDS = 8;
    localparam int unsigned MBOX_DW    = 32;
    localparam int unsigned MBOX_AW    = $clog2(MBOX_WORDS);
    localparam int unsigned LAST_IDX   = MBOX_WORDS - 1;
    localparam int unsigned OWN_BIT    = MBOX_DW - 1;

    typedef logic [MBOX_AW-1:0] waddr_t;
    typedef logic [MBOX_DW-1:0] word_t;

    typedef struct packed {
        logic   en;
        waddr_t addr;
        word_t  data;
    } wr_t;

    typedef enum logic {
        OWNER_REQ = 1'b0,
        OWNER_RSP = 1'b1
    } owner_e;

    localparam waddr_t LAST_ADDR = waddr_t'(LAST_IDX);

    function automatic logic wr_hits(input wr_t w, input int unsigned idx);
        return w.en && (w.addr == waddr_t'(idx));
    endfunction

    function automatic word_t mark_handoff(input word_t d);
        word_t r;
        r = d;
        r[OWN_BIT] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/hm_store.sv
module hm_store
    import handoff_mbox_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  wr_t   wa,
    input  wr_t   wb,
    output word_t words [MBOX_WORDS]
);

    // One register per word; port A has priority over port B.
    for (genvar i = 0; i < MBOX_WORDS; i++) begin : g_word
        word_t q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_hits(wa, i)) begin
                q <= wa.data;
            end else if (wr_hits(wb, i)) begin
                q <= wb.data;
            end
        end
        assign words[i] = q;
    end

endmodule

// File: rtl/hm_arbiter.sv
module hm_arbiter
    import handoff_mbox_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   fn_rst,
    input  wr_t    req_in,
    input  wr_t    rsp_in,
    input  owner_e owner,
    output wr_t    wa,
    output wr_t    wb,
    output logic   doorbell,
    output logic   err
);

    logic req_live, req_take, req_drop, same_word;
    logic db_q, err_q;

    always_comb begin
        req_live  = req_in.en && !fn_rst;
        req_take  = req_live && (owner == OWNER_REQ);
        req_drop  = req_live && (owner == OWNER_RSP);
        same_word = req_in.addr == rsp_in.addr;

        wa.en   = req_take;
        wa.addr = req_in.addr;
        wa.data = (req_in.addr == LAST_ADDR) ? mark_handoff(req_in.data) : req_in.data;

        wb      = rsp_in;
        wb.en   = rsp_in.en && !(req_take && same_word);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            db_q  <= 1'b0;
            err_q <= 1'b0;
        end else begin
            db_q  <= req_take && (req_in.addr == LAST_ADDR);
            err_q <= err_q | req_drop;
        end
    end

    assign doorbell = db_q;
    assign err      = err_q;

    // R7
    blocked_sets_err_chk: assert property (@(posedge clk) disable iff (rst)
        (req_in.en && !fn_rst && owner == OWNER_RSP) |=> err);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R4
    doorbell_single_chk: assert property (@(posedge clk) disable iff (rst)
        doorbell |=> !doorbell);

endmodule

// File: rtl/hm_readport.sv
module hm_readport
    import handoff_mbox_pkg::*;
(
    input  logic   fn_rst,
    input  waddr_t addr,
    input  word_t  words [MBOX_WORDS],
    output word_t  rdata
);

    always_comb begin
        if (fn_rst) rdata = '1;
        else        rdata = words[addr];
    end

endmodule

// File: rtl/handoff_mbox.sv
module handoff_mbox
    import handoff_mbox_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                fn_rst,
    input  logic                req_we,
    input  logic [MBOX_AW-1:0]  req_addr,
    input  logic [MBOX_DW-1:0]  req_wdata,
    output logic [MBOX_DW-1:0]  req_rdata,
    input  logic                rsp_we,
    input  logic [MBOX_AW-1:0]  rsp_addr,
    input  logic [MBOX_DW-1:0]  rsp_wdata,
    output logic [MBOX_DW-1:0]  rsp_rdata,
    output logic                rsp_owns,
    output logic                doorbell,
    output logic                req_err
);

    wr_t    req_in, rsp_in, wa, wb;
    word_t  words [MBOX_WORDS];
    owner_e owner;

    assign req_in = '{en: req_we, addr: req_addr, data: req_wdata};
    assign rsp_in = '{en: rsp_we, addr: rsp_addr, data: rsp_wdata};

    assign owner    = owner_e'(words[LAST_IDX][OWN_BIT]);
    assign rsp_owns = (owner == OWNER_RSP);

    hm_arbiter u_arb (
        .clk      (clk),
        .rst      (rst),
        .fn_rst   (fn_rst),
        .req_in   (req_in),
        .rsp_in   (rsp_in),
        .owner    (owner),
        .wa       (wa),
        .wb       (wb),
        .doorbell (doorbell),
        .err      (req_err)
    );

    hm_store u_store (
        .clk   (clk),
        .rst   (rst),
        .wa    (wa),
        .wb    (wb),
        .words (words)
    );

    hm_readport u_rd_req (
        .fn_rst (fn_rst),
        .addr   (req_addr),
        .words  (words),
        .rdata  (req_rdata)
    );

    hm_readport u_rd_rsp (
        .fn_rst (fn_rst),
        .addr   (rsp_addr),
        .words  (words),
        .rdata  (rsp_rdata)
    );

    // R2
    post_reset_chk: assert property (@(posedge clk)
        $past(rst) |-> (!rsp_owns && !req_err && !doorbell));

    // R3
    handoff_sets_owner_chk: assert property (@(posedge clk) disable iff (rst)
        (!rsp_owns && req_we && !fn_rst && req_addr == LAST_ADDR) |=> (rsp_owns && doorbell));

    // R5
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_owns && rsp_we && rsp_addr == LAST_ADDR && !rsp_wdata[OWN_BIT]) |=> !rsp_owns);

    // R6
    blocked_word_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_owns && req_we && !rsp_we) |=> (words[$past(req_addr)] == $past(words[req_addr])));

    // R8
    fnrst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fn_rst && req_we && !rsp_we) |=> (words[$past(req_addr)] == $past(words[req_addr])));

    // R9
    owner_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (!rsp_owns && !fn_rst && req_we && rsp_we && req_addr == rsp_addr && req_addr != LAST_ADDR)
        |=> (words[$past(req_addr)] == $past(req_wdata)));

endmodule

// File: tb/sim_handoff_mbox.sv
module sim_handoff_mbox;
    import handoff_mbox_pkg::*;

    localparam time CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fn_rst = 1'b0;
    logic        req_we = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] req_rdata;
    logic        rsp_we = 1'b0;
    logic [2:0]  rsp_addr = '0;
    logic [31:0] rsp_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        rsp_owns, doorbell, req_err;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    handoff_mbox u0 (
        .clk(clk), .rst(rst), .fn_rst(fn_rst),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_rdata(req_rdata),
        .rsp_we(rsp_we), .rsp_addr(rsp_addr), .rsp_wdata(rsp_wdata), .rsp_rdata(rsp_rdata),
        .rsp_owns(rsp_owns), .doorbell(doorbell), .req_err(req_err)
    );

    typedef struct packed {
        logic        rq_we;
        logic [2:0]  rq_a;
        logic [31:0] rq_d;
        logic        rs_we;
        logic [2:0]  rs_a;
        logic [31:0] rs_d;
        logic [2:0]  chk_a;
        logic [31:0] chk_d;
        logic        own;
        logic        err;
        logic        db;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        // R1 plain requester writes
        '{1'b1, 3'd0, 32'hA000_00A0, 1'b0, 3'd0, 32'h0,          3'd0, 32'hA000_00A0, 1'b0, 1'b0, 1'b0},
        '{1'b1, 3'd6, 32'hA600_0006, 1'b0, 3'd0, 32'h0,          3'd6, 32'hA600_0006, 1'b0, 1'b0, 1'b0},
        // R10 responder writes while requester owns
        '{1'b0, 3'd0, 32'h0,          1'b1, 3'd3, 32'hB300_0003, 3'd3, 32'hB300_0003, 1'b0, 1'b0, 1'b0},
        // R9 collision, requester owns
        '{1'b1, 3'd2, 32'hC200_0002, 1'b1, 3'd2, 32'hD200_0002, 3'd2, 32'hC200_0002, 1'b0, 1'b0, 1'b0},
        // R3 R4 handoff
        '{1'b1, 3'd7, 32'h0000_0011, 1'b0, 3'd0, 32'h0,          3'd7, 32'h8000_0011, 1'b1, 1'b0, 1'b1},
        // R6 R7 blocked write
        '{1'b1, 3'd0, 32'hEEEE_EEEE, 1'b0, 3'd0, 32'h0,          3'd0, 32'hA000_00A0, 1'b1, 1'b1, 1'b0},
        // R10 responder writes while it owns
        '{1'b0, 3'd0, 32'h0,          1'b1, 3'd1, 32'hF100_0001, 3'd1, 32'hF100_0001, 1'b1, 1'b1, 1'b0},
        // R9 collision, responder owns
        '{1'b1, 3'd5, 32'h5555_5555, 1'b1, 3'd5, 32'h6666_6666, 3'd5, 32'h6666_6666, 1'b1, 1'b1, 1'b0},
        // R5 header with bit 31 set keeps ownership
        '{1'b0, 3'd0, 32'h0,          1'b1, 3'd7, 32'h8000_0022, 3'd7, 32'h8000_0022, 1'b1, 1'b1, 1'b0},
        // R5 header with bit 31 clear returns ownership
        '{1'b0, 3'd0, 32'h0,          1'b1, 3'd7, 32'h0100_0002, 3'd7, 32'h0100_0002, 1'b0, 1'b1, 1'b0},
        // R7 sticky error survives later good writes
        '{1'b1, 3'd4, 32'h4444_0004, 1'b0, 3'd0, 32'h0,          3'd4, 32'h4444_0004, 1'b0, 1'b1, 1'b0},
        // R3 second handoff with bit 31 forced
        '{1'b1, 3'd7, 32'h1234_0001, 1'b0, 3'd0, 32'h0,          3'd7, 32'h9234_0001, 1'b1, 1'b1, 1'b1},
        // R5 release with zero header
        '{1'b0, 3'd0, 32'h0,          1'b1, 3'd7, 32'h0000_0000, 3'd7, 32'h0000_0000, 1'b0, 1'b1, 1'b0}
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin : main
        // Reset state: R2
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int a = 0; a < 8; a++) begin
            req_addr = 3'(a);
            rsp_addr = 3'(a);
            #1;
            check(req_rdata == 32'h0, "R2 req word zero", req_rdata, 32'h0);
            check(rsp_rdata == 32'h0, "R2 rsp word zero", rsp_rdata, 32'h0);
        end
        check(rsp_owns == 1'b0, "R2 owner", 32'(rsp_owns), 32'h0);
        check(req_err == 1'b0, "R2 err", 32'(req_err), 32'h0);
        check(doorbell == 1'b0, "R2 doorbell", 32'(doorbell), 32'h0);

        // Function reset: R8
        @(negedge clk);
        fn_rst = 1'b1;
        for (int a = 0; a < 8; a++) begin
            req_addr = 3'(a);
            rsp_addr = 3'(7 - a);
            #1;
            check(req_rdata == 32'hFFFF_FFFF, "R8 req all ones", req_rdata, 32'hFFFF_FFFF);
            check(rsp_rdata == 32'hFFFF_FFFF, "R8 rsp all ones", rsp_rdata, 32'hFFFF_FFFF);
        end
        @(negedge clk);
        req_we = 1'b1; req_addr = 3'd0; req_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        req_addr = 3'd7; req_wdata = 32'h0000_0001;
        @(negedge clk);
        req_we = 1'b0;
        fn_rst = 1'b0;
        req_addr = 3'd0;
        #1;
        check(req_rdata == 32'h0, "R8 write ignored", req_rdata, 32'h0);
        check(req_err == 1'b0, "R8 no error", 32'(req_err), 32'h0);
        check(rsp_owns == 1'b0, "R8 no handoff", 32'(rsp_owns), 32'h0);
        check(doorbell == 1'b0, "R8 no doorbell", 32'(doorbell), 32'h0);

        // Vector table: R1 R3 R4 R5 R6 R7 R9 R10
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            req_we = VECS[i].rq_we; req_addr = VECS[i].rq_a; req_wdata = VECS[i].rq_d;
            rsp_we = VECS[i].rs_we; rsp_addr = VECS[i].rs_a; rsp_wdata = VECS[i].rs_d;
            @(negedge clk);
            req_we = 1'b0; rsp_we = 1'b0;
            req_addr = VECS[i].chk_a;
            rsp_addr = VECS[i].chk_a;
            #1;
            check(req_rdata == VECS[i].chk_d, $sformatf("vec%0d R1 word", i), req_rdata, VECS[i].chk_d);
            check(rsp_rdata == VECS[i].chk_d, $sformatf("vec%0d R10 rsp view", i), rsp_rdata, VECS[i].chk_d);
            check(rsp_owns == VECS[i].own, $sformatf("vec%0d R3 owner", i), 32'(rsp_owns), 32'(VECS[i].own));
            check(req_err == VECS[i].err, $sformatf("vec%0d R7 err", i), 32'(req_err), 32'(VECS[i].err));
            check(doorbell == VECS[i].db, $sformatf("vec%0d R4 doorbell", i), 32'(doorbell), 32'(VECS[i].db));
        end

        // R4: the doorbell lasts one cycle only
        @(negedge clk);
        req_we = 1'b1; req_addr = 3'd7; req_wdata = 32'h0000_0033;
        @(negedge clk);
        req_we = 1'b0;
        #1;
        check(doorbell == 1'b1, "R4 pulse high", 32'(doorbell), 32'h1);
        @(negedge clk);
        #1;
        check(doorbell == 1'b0, "R4 pulse gone", 32'(doorbell), 32'h0);

        // R8 during responder ownership: reads all ones, contents return
        fn_rst = 1'b1;
        req_addr = 3'd7;
        #1;
        check(req_rdata == 32'hFFFF_FFFF, "R8 owned all ones", req_rdata, 32'hFFFF_FFFF);
        @(negedge clk);
        fn_rst = 1'b0;
        #1;
        check(req_rdata == 32'h8000_0033, "R8 contents return", req_rdata, 32'h8000_0033);

        // R2 R7: power-on reset clears the sticky error and ownership
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        req_addr = 3'd6;
        #1;
        check(req_err == 1'b0, "R7 err cleared by reset", 32'(req_err), 32'h0);
        check(rsp_owns == 1'b0, "R2 owner after reset", 32'(rsp_owns), 32'h0);
        check(req_rdata == 32'h0, "R2 word cleared", req_rdata, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule